// File: doc/BRIEF.md
# Control Command Register Access Engine

This block sits behind the word assembler of a device's serial host port and carries out register access commands. Each command starts with a 32-bit header word. The header says whether the command reads or writes, which register map and start address to use, how many registers to touch, and whether the address steps forward after each access. The engine turns the header into a run of accesses on a simple internal register bus. It returns a response word for every word it accepts.

The response stream lags the incoming stream by exactly one word. For the slot where the header arrives, the engine returns a zero word. In the next slot it returns the header, checked and cleaned. After that come the write data it accepted, or the data it read. A command of N registers therefore takes N+2 words. Several commands may follow one another while the port stays selected. Deselecting the port cancels whatever is still in flight. A small register file on the same bus gives the engine something to reach for test.

Top module: `ctl_cmd_engine`

## Requirements
- R1: A header word with bit 31 at 0 is a command, and bit 29 picks write (1) or read (0). A header with bit 31 at 1 is not carried out: it and every later word until deselection return zero, and no register changes.
- R2: Each word accepted while selected yields `out_valid` on the next cycle. `out_word` in slot k is the response set up by slot k-1: zero for a header slot that opens a selection or follows a finished command, the echoed header in the next slot, then one data word per register.
- R3: Bits 7..1 give the register count minus one, so 0 means one register and 127 means 128. Exactly one further word follows the data words, and the next word after it is a new header.
- R4: With bit 28 at 0 the address rises by one after every access. With bit 28 at 1 every access in the command uses the start address.
- R5: Bits 27..24 select the map and bits 23..8 the start address. The register file implements maps 0..NUM_MAPS-1 with addresses 0..NUM_REGS-1, all at 0 after reset. A write anywhere else changes nothing, and a read anywhere else returns 0.
- R6: A header is valid only if the XOR of all its bits except bit 30 is 1. For a header that fails, the echo is the received word with bit 30 forced to 1 and bit 0 recomputed so that all 32 bits have odd parity. No access takes place, and every later word until deselection returns zero.
- R7: Bit 30 of a header, as received, has no effect on the parity check. The echo of an accepted header carries bit 30 at 0 and is otherwise the received word.
- R8: In a read command, the words that arrive in the data slots are ignored. They write nothing and do not appear in the response.
- R9: In a write command, each data word is written and echoed. The one extra word after the data is never written, not even to the address that would come next.
- R10: Commands may be placed back to back within one selection. A read sees the writes of the commands before it.
- R11: Raising `frame_n` cancels any remaining accesses and returns the engine to waiting for a header. Words offered while deselected produce no `out_valid`.
- R12: After reset, `out_valid` and `out_word` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_n | input | 1 | Port select, active low; high ends the current selection |
| in_valid | input | 1 | A received 32-bit word is present this cycle |
| in_word | input | 32 | Received word from the host |
| out_valid | output | 1 | Response word present, one cycle after an accepted word |
| out_word | output | 32 | Response word for the slot just accepted |

## Verification
The bench builds the engine with its default two maps of eight registers. At that size a sweep can write every implemented address, plus a ring of addresses just outside them, and read the whole space back. The sweep includes a map that does not exist and addresses past the end of each map. Burst lengths from one to eight cover every possible position of the ignored extra word. A single 128-register read reaches the largest count and runs far past the implemented range. The remaining frames cover address hold, bad and non-command headers, a set bit 30, and an abort in the middle of a burst.

// File: rtl/ctl_cmd_pkg.sv
// Shared definitions for the control command engine.
// Assumes 32-bit command words; header field positions are fixed here.
package ctl_cmd_pkg;

    localparam int CMD_W      = 32;
    localparam int B_KIND     = 31;  // 0 = command word
    localparam int B_BAD      = 30;  // header-bad flag in the echo
    localparam int B_WRITE    = 29;
    localparam int B_HOLD     = 28;  // address hold
    localparam int MAP_LSB    = 24;
    localparam int MAP_W      = 4;
    localparam int ADDR_LSB   = 8;
    localparam int ADDR_W     = 16;
    localparam int CNT_LSB    = 1;
    localparam int CNT_W      = 7;
    localparam int LEFT_W     = CNT_W + 1;

    typedef enum logic [1:0] {
        ST_IDLE,   // waiting for a header
        ST_DATA,   // data slots of an accepted command
        ST_TAIL,   // the one extra slot after the data
        ST_DROP    // discard until deselect
    } ctl_state_e;

    typedef struct packed {
        logic              is_cmd;
        logic              wr;
        logic              hold;
        logic [MAP_W-1:0]  map;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt_m1;
        logic              par_ok;
    } ctl_hdr_t;

endpackage

// File: rtl/ctl_hdr_decode.sv
// Header decoder: splits a received word into command fields, checks odd
// parity over every bit except the header-bad bit, and builds the echo word.
// Assumes nothing about state; purely combinational.
module ctl_hdr_decode
    import ctl_cmd_pkg::*;
(
    input  logic [CMD_W-1:0] word_i,
    output ctl_hdr_t         hdr_o,
    output logic [CMD_W-1:0] echo_o
);

    logic [CMD_W-1:0] masked;
    logic [CMD_W-1:0] echo_raw;

    // Field extraction and parity check (host bit 30 excluded).
    always_comb begin
        masked         = word_i;
        masked[B_BAD]  = 1'b0;
        hdr_o.is_cmd   = ~word_i[B_KIND];
        hdr_o.wr       = word_i[B_WRITE];
        hdr_o.hold     = word_i[B_HOLD];
        hdr_o.map      = word_i[MAP_LSB +: MAP_W];
        hdr_o.addr     = word_i[ADDR_LSB +: ADDR_W];
        hdr_o.cnt_m1   = word_i[CNT_LSB +: CNT_W];
        hdr_o.par_ok   = ^masked;
    end

    // Echo: bit 30 reports the parity result, bit 0 restores odd parity.
    always_comb begin
        echo_raw        = word_i;
        echo_raw[B_BAD] = ~hdr_o.par_ok;
        echo_raw[0]     = 1'b0;
        echo_o          = echo_raw;
        echo_o[0]       = ~^echo_raw;
    end

endmodule

// File: rtl/ctl_cmd_seq.sv
// Command sequencer: accepts one word per in_valid while selected, runs the
// burst on the register bus and returns the response one word late.
// Assumes the register bus answers reads combinationally in the same cycle.
module ctl_cmd_seq
    import ctl_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic              in_valid,
    input  logic [CMD_W-1:0]  in_word,
    input  ctl_hdr_t          hdr_i,
    input  logic [CMD_W-1:0]  hdr_echo_i,
    output logic              bus_req,
    output logic              bus_we,
    output logic [MAP_W-1:0]  bus_map,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [CMD_W-1:0]  bus_wdata,
    input  logic [CMD_W-1:0]  bus_rdata,
    output logic              out_valid,
    output logic [CMD_W-1:0]  out_word
);

    ctl_state_e        state_q;
    logic [CMD_W-1:0]  echo_q;
    logic              wr_q;
    logic              hold_q;
    logic [MAP_W-1:0]  map_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEFT_W-1:0] left_q;
    logic              acc;

    // A word counts only while the port is selected.
    assign acc = in_valid & ~frame_n;

    // Register bus drive during data slots.
    assign bus_req   = acc && (state_q == ST_DATA);
    assign bus_we    = wr_q;
    assign bus_map   = map_q;
    assign bus_addr  = addr_q;
    assign bus_wdata = in_word;

    // Slot sequencing, echo staging and address stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            echo_q    <= '0;
            wr_q      <= 1'b0;
            hold_q    <= 1'b0;
            map_q     <= '0;
            addr_q    <= '0;
            left_q    <= '0;
            out_valid <= 1'b0;
            out_word  <= '0;
        end else if (frame_n) begin
            state_q   <= ST_IDLE;
            echo_q    <= '0;
            left_q    <= '0;
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_word <= echo_q;
                unique case (state_q)
                    ST_IDLE: begin
                        if (!hdr_i.is_cmd) begin
                            echo_q  <= '0;
                            state_q <= ST_DROP;
                        end else if (!hdr_i.par_ok) begin
                            echo_q  <= hdr_echo_i;
                            state_q <= ST_DROP;
                        end else begin
                            echo_q  <= hdr_echo_i;
                            wr_q    <= hdr_i.wr;
                            hold_q  <= hdr_i.hold;
                            map_q   <= hdr_i.map;
                            addr_q  <= hdr_i.addr;
                            left_q  <= {1'b0, hdr_i.cnt_m1} + LEFT_W'(1);
                            state_q <= ST_DATA;
                        end
                    end
                    ST_DATA: begin
                        echo_q <= wr_q ? in_word : bus_rdata;
                        if (!hold_q) addr_q <= addr_q + ADDR_W'(1);
                        left_q <= left_q - LEFT_W'(1);
                        if (left_q == LEFT_W'(1)) state_q <= ST_TAIL;
                    end
                    ST_TAIL: begin
                        echo_q  <= '0;
                        state_q <= ST_IDLE;
                    end
                    default: begin
                        echo_q <= '0;
                    end
                endcase
            end
        end
    end

    // R11: deselection always returns to idle with no response pending.
    a_r11_deselect_idle: assert property (@(posedge clk) disable iff (!rst_n)
        frame_n |=> (state_q == ST_IDLE) && !out_valid);

    // R6: the discard state never touches the register bus.
    a_r6_drop_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DROP) |-> !bus_req);

    // R3: a burst in progress always has between 1 and 128 accesses left.
    a_r3_left_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA) |-> (left_q != '0) && (left_q <= LEFT_W'(128)));

    // R4: with address hold the address stays put across data slots.
    a_r4_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && state_q == ST_DATA && hold_q) |=> (addr_q == $past(addr_q)));

    // R2: each accepted word gives a response next cycle carrying the staged word.
    a_r2_echo_lag: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> out_valid && (out_word == $past(echo_q)));

endmodule

// File: rtl/ctl_reg_file.sv
// Test register file: NUM_MAPS maps of NUM_REGS 32-bit registers, reset to 0.
// Out-of-range writes are dropped, and out-of-range reads return 0.
module ctl_reg_file
    import ctl_cmd_pkg::*;
#(
    parameter int NUM_MAPS = 2,
    parameter int NUM_REGS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [MAP_W-1:0]  map_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CMD_W-1:0]  wdata_i,
    output logic [CMD_W-1:0]  rdata_o
);

    localparam int TOTAL  = NUM_MAPS * NUM_REGS;
    localparam int SEL_W  = (TOTAL > 1) ? $clog2(TOTAL) : 1;
    localparam int FLAT_W = MAP_W + ADDR_W + 8;

    logic [CMD_W-1:0]  mem_q [TOTAL];
    logic              hit;
    logic [FLAT_W-1:0] flat;
    logic [SEL_W-1:0]  sel;

    // Address decode into the flat storage index.
    always_comb begin
        hit  = (32'(map_i) < 32'(NUM_MAPS)) && (32'(addr_i) < 32'(NUM_REGS));
        flat = FLAT_W'(map_i) * FLAT_W'(NUM_REGS) + FLAT_W'(addr_i);
        sel  = flat[SEL_W-1:0];
    end

    // Combinational read, zero outside the implemented range.
    assign rdata_o = hit ? mem_q[sel] : '0;

    // Storage update on an in-range write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < TOTAL; i++) mem_q[i] <= '0;
        end else if (req_i && we_i && hit) begin
            mem_q[sel] <= wdata_i;
        end
    end

    // R5: an out-of-range write leaves the addressed-by-index slot unchanged.
    a_r5_miss_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && we_i && !hit) |=> $stable(mem_q[$past(sel)]));

endmodule

// File: rtl/ctl_cmd_engine.sv
// Control command engine top: header decoder, sequencer and test register
// file. Assumes word framing is done upstream: one in_valid per 32-bit word.
module ctl_cmd_engine
    import ctl_cmd_pkg::*;
#(
    parameter int NUM_MAPS = 2,
    parameter int NUM_REGS = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_n,
    input  logic        in_valid,
    input  logic [31:0] in_word,
    output logic        out_valid,
    output logic [31:0] out_word
);

    ctl_hdr_t          hdr;
    logic [CMD_W-1:0]  hdr_echo;
    logic              bus_req;
    logic              bus_we;
    logic [MAP_W-1:0]  bus_map;
    logic [ADDR_W-1:0] bus_addr;
    logic [CMD_W-1:0]  bus_wdata;
    logic [CMD_W-1:0]  bus_rdata;

    ctl_hdr_decode u_dec (
        .word_i (in_word),
        .hdr_o  (hdr),
        .echo_o (hdr_echo)
    );

    ctl_cmd_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_n    (frame_n),
        .in_valid   (in_valid),
        .in_word    (in_word),
        .hdr_i      (hdr),
        .hdr_echo_i (hdr_echo),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_map    (bus_map),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .out_valid  (out_valid),
        .out_word   (out_word)
    );

    ctl_reg_file #(
        .NUM_MAPS (NUM_MAPS),
        .NUM_REGS (NUM_REGS)
    ) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (bus_req),
        .we_i    (bus_we),
        .map_i   (bus_map),
        .addr_i  (bus_addr),
        .wdata_i (bus_wdata),
        .rdata_o (bus_rdata)
    );

endmodule

// File: tb/ctl_cmd_engine_bench.sv
module ctl_cmd_engine_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NM = 2;
    localparam int NR = 8;
    localparam int MAXW = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        out_valid;
    logic [31:0] out_word;

    int errs = 0;
    int checks = 0;
    logic [31:0] mdl [NM*NR];
    logic [31:0] txw [MAXW];
    logic [31:0] expw [MAXW];
    int n_tx = 0;

    ctl_cmd_engine #(.NUM_MAPS(NM), .NUM_REGS(NR)) u_ctl_cmd_engine (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .in_valid(in_valid),
        .in_word(in_word), .out_valid(out_valid), .out_word(out_word)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_hdr(input logic wr, input logic hold, input int map, input int addr, input int cnt);
        logic [31:0] h;
        logic [3:0]  m4  = map[3:0];
        logic [15:0] a16 = addr[15:0];
        logic [6:0]  c7  = 7'(cnt - 1);
        h = {2'b00, wr, hold, m4, a16, c7, 1'b0};
        h[0] = ~^h;
        return h;
    endfunction

    function automatic logic [31:0] mdl_rd(input int map, input int addr);
        if (map < NM && addr < NR) return mdl[map*NR + addr];
        return '0;
    endfunction

    task automatic mdl_wr(input int map, input int addr, input logic [31:0] d);
        if (map < NM && addr < NR) mdl[map*NR + addr] = d;
    endtask

    task automatic clr_frame();
        n_tx = 0;
        for (int i = 0; i < MAXW; i++) begin
            txw[i] = '0;
            expw[i] = '0;
        end
    endtask

    task automatic add_wr(input int map, input int addr, input logic hold, input int cnt, input logic [31:0] seed);
        int p = n_tx;
        int a = addr;
        logic [31:0] h = mk_hdr(1'b1, hold, map, addr, cnt);
        txw[p] = h;
        expw[p+1] = h;
        for (int i = 0; i < cnt; i++) begin
            logic [31:0] d = seed + 32'(i) * 32'h0101_0101;
            txw[p+1+i] = d;
            expw[p+2+i] = d;
            mdl_wr(map, a, d);
            if (!hold) a = (a + 1) & 16'hFFFF;
        end
        txw[p+1+cnt] = 32'hA5A5_0000 ^ seed;  // R9: extra word, never written
        n_tx = p + cnt + 2;
    endtask

    task automatic add_rd(input int map, input int addr, input logic hold, input int cnt);
        int p = n_tx;
        int a = addr;
        logic [31:0] h = mk_hdr(1'b0, hold, map, addr, cnt);
        txw[p] = h;
        expw[p+1] = h;
        for (int i = 0; i < cnt; i++) begin
            txw[p+1+i] = 32'hFFFF_FFF0 ^ 32'(i);  // R8: filler, must be ignored
            expw[p+2+i] = mdl_rd(map, a);
            if (!hold) a = (a + 1) & 16'hFFFF;
        end
        txw[p+1+cnt] = 32'h5A5A_5A5A;
        n_tx = p + cnt + 2;
    endtask

    task automatic send(input logic [31:0] w, output logic [31:0] got, output logic gotv);
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
        @(negedge clk);
        got  = out_word;
        gotv = out_valid;
        in_valid = 1'b0;
    endtask

    task automatic run_frame(input string req);
        logic [31:0] got;
        logic gv;
        @(negedge clk);
        frame_n = 1'b0;
        for (int k = 0; k < n_tx; k++) begin
            send(txw[k], got, gv);
            check(gv == 1'b1, {req, " R2 valid"}, 32'(gv), 32'd1);
            check(got == expw[k], req, got, expw[k]);
        end
        @(negedge clk);
        frame_n = 1'b1;
        @(negedge clk);
        clr_frame();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errs++;
        $display("FAIL watchdog R2 act=hung exp=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [31:0] got;
        logic gv;
        logic [31:0] h;
        logic [31:0] e;
        for (int i = 0; i < NM*NR; i++) mdl[i] = '0;
        clr_frame();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        check(out_valid == 1'b0, "R12 out_valid", 32'(out_valid), 32'd0);
        check(out_word == '0, "R12 out_word", out_word, 32'd0);
        add_rd(0, 0, 1'b0, NR);
        run_frame("R12 regs zero");

        // R5 sweep: single writes over maps 0..2, addresses 0..9
        for (int m = 0; m < 3; m++)
            for (int a = 0; a < 10; a++) begin
                add_wr(m, a, 1'b0, 1, {8'(m), 8'(a), 16'hC0DE});
                run_frame("R5 single write");
            end
        // R10/R5: read back all three maps in one selection
        for (int m = 0; m < 3; m++) add_rd(m, 0, 1'b0, 10);
        run_frame("R10 R5 readback");

        // R3/R9: burst lengths 1..8 each followed by a full read in the same frame
        for (int c = 1; c <= 8; c++) begin
            add_wr(1, 0, 1'b0, c, 32'h1000_0000 * 32'(c));
            add_rd(1, 0, 1'b0, NR);
            run_frame("R3 R9 burst");
        end

        // R4: address hold on write and read
        add_wr(0, 3, 1'b1, 3, 32'h7700_0011);
        add_rd(0, 2, 1'b0, 3);
        add_rd(0, 3, 1'b1, 4);
        run_frame("R4 hold");

        // R3: largest count, 128 reads running past the map end
        add_rd(0, 0, 1'b0, 128);
        run_frame("R3 max count");

        // R6: bad parity, nothing executed, trailing header dropped
        h = mk_hdr(1'b1, 1'b0, 0, 2, 1) ^ 32'h1;
        e = h | 32'h4000_0000;
        e[0] = 1'b0;
        e[0] = ~^e;
        txw[0] = h; txw[1] = 32'hBAD0_BAD0; txw[2] = 32'h0;
        txw[3] = mk_hdr(1'b0, 1'b0, 0, 0, 1); txw[4] = 32'h0; txw[5] = 32'h0;
        expw[1] = e;
        n_tx = 6;
        run_frame("R6 bad parity");
        add_rd(0, 2, 1'b0, 1);
        run_frame("R6 no write");

        // R1: data-kind header is not executed
        txw[0] = 32'hA020_0001; txw[1] = mk_hdr(1'b1, 1'b0, 0, 1, 1);
        txw[2] = 32'h1234_5678; txw[3] = 32'h0;
        n_tx = 4;
        run_frame("R1 not command");
        add_rd(0, 1, 1'b0, 1);
        run_frame("R1 no write");

        // R7: host bit 30 set on a valid header is ignored
        add_wr(1, 5, 1'b0, 2, 32'h0BAD_F00D);
        txw[0] = txw[0] | 32'h4000_0000;
        run_frame("R7 bit30 ignored");
        add_rd(1, 5, 1'b0, 2);
        run_frame("R7 readback");

        // R11: abort after two of four writes
        h = mk_hdr(1'b1, 1'b0, 1, 0, 4);
        txw[0] = h; txw[1] = 32'hABCD_0001; txw[2] = 32'hABCD_0002;
        expw[1] = h; expw[2] = 32'hABCD_0001;
        mdl_wr(1, 0, 32'hABCD_0001);
        mdl_wr(1, 1, 32'hABCD_0002);
        n_tx = 3;
        run_frame("R11 abort");
        send(32'h0000_0001, got, gv);
        check(gv == 1'b0, "R11 deselected word", 32'(gv), 32'd0);
        add_rd(1, 0, 1'b0, 4);
        run_frame("R11 readback");

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule